// File: doc/BRIEF.md
# Count/Compare Timer

This block is a free-running cycle counter with a compare register. Each enabled clock moves the count up by one. When the count steps onto the value held in the compare register, the block raises a timer interrupt request that is wired to interrupt line 7 of the core. The request stays high until software rewrites the compare register. Software can also load the count directly, and a disable-count control from the core's cause logic can freeze the counter.

On cores whose architecture-revision input carries the value 1, the block also keeps a separate timer-pending status bit. The core maps this bit into bit 30 of its cause register. The bit is set by the same match event and cleared by the same compare write. On every other revision the bit reads as zero. Clock division and the rest of the cause register are handled outside this block.

Top module: `count_compare_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the count is 0, the compare register is 0, the interrupt request is low and the status bit is low.
- R2: On each clock with `tick_en` high, `count_hold` low and no count write, the count increases by exactly one. From 0xFFFFFFFF it wraps to 0. With `tick_en` low the count does not change.
- R3: While `count_hold` (the disable-count control, cause bit 27) is high, the counter does not advance.
- R4: A count write (`cnt_wr`) loads `wr_data` into the count on that clock edge. The write takes priority over counting and works while the count is held. It does not clear a pending interrupt and does not by itself raise one.
- R5: The interrupt request rises on the same clock edge on which the count advances onto the compare value.
- R6: Once raised, the interrupt request stays high while the count moves past the compare value, until the compare register is written.
- R7: A compare write (`cmp_wr`) loads `wr_data` into the compare register and deasserts the interrupt request on that edge. It wins over a match that happens on the same edge.
- R8: A match sets the status bit only if `arch_rev` equals 3'b001 on the match edge.
- R9: A compare write clears the status bit. `timer_stat` reads as 0 whenever `arch_rev` is not 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for this cycle |
| cnt_wr | input | 1 | Software write strobe for the count |
| cmp_wr | input | 1 | Software write strobe for the compare register |
| wr_data | input | 32 | Write data shared by both strobes |
| count_hold | input | 1 | Disable-count control; freezes the counter |
| arch_rev | input | 3 | Architecture revision; 3'b001 enables the status bit |
| count_q | output | 32 | Current count |
| timer_irq | output | 1 | Interrupt request for line 7 |
| timer_stat | output | 1 | Timer-pending status, bound for cause bit 30 |

## Verification
The bench checks that the interrupt rises on the exact edge the count reaches the compare value. A design that compared one cycle late would show the count at compare+1 when the request first rises. The bench also exercises these corner cases:
- A compare write that lands on the same edge as a match. The clear must win; a design that let the match win would leave the request stuck high.
- The count wrapping from 0xFFFFFFFF onto a small compare value. A design with a wrong carry would stall or skip the match.
- A count write while an interrupt is pending. A design that cleared the request here would lose the interrupt.
- A count write while the counter is frozen. A design that gated the write with the freeze would ignore the load.
- The revision input moving away from 3'b001. A design that did not gate the status bit on revision would show a status bit on the wrong cores.

// File: rtl/count_compare_timer.sv
module count_compare_timer #(
  parameter int W        = 32,
  parameter int REV_W    = 3,
  parameter int STAT_REV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [W-1:0]     wr_data,
  input  logic             count_hold,
  input  logic [REV_W-1:0] arch_rev,
  output logic [W-1:0]     count_q,
  output logic             timer_irq,
  output logic             timer_stat
);

  localparam logic [REV_W-1:0] REV_SEL = REV_W'(STAT_REV);

  logic [W-1:0] cmp_q;
  logic [W-1:0] count_inc;
  logic         advance;
  logic         hit;
  logic         rev_ok;
  logic         stat_q;

  assign advance   = tick_en && !count_hold && !cnt_wr;
  assign count_inc = count_q + W'(1);
  assign hit       = advance && (count_inc == cmp_q);
  assign rev_ok    = (arch_rev == REV_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_wr) begin
      count_q <= wr_data;
    end else if (advance) begin
      count_q <= count_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_wr) begin
      cmp_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_irq <= 1'b0;
      stat_q    <= 1'b0;
    end else if (cmp_wr) begin
      timer_irq <= 1'b0;
      stat_q    <= 1'b0;
    end else if (hit) begin
      timer_irq <= 1'b1;
      stat_q    <= stat_q | rev_ok;
    end
  end

  assign timer_stat = stat_q && rev_ok;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !count_hold && !cnt_wr) |=> (count_q == $past(count_q) + W'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hold && !cnt_wr) |=> $stable(count_q));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(wr_data)));

  assert_rise_at_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_irq) |-> (count_q == cmp_q));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq && !cmp_wr) |=> timer_irq);

  assert_cmp_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !timer_irq);

  assert_stat_needs_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_stat |-> timer_irq);

endmodule

// File: tb/count_compare_timer_bench.sv
module count_compare_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cnt_wr = 1'b0;
  logic        cmp_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        count_hold = 1'b0;
  logic [2:0]  arch_rev = 3'd1;
  logic [31:0] count_q;
  logic        timer_irq;
  logic        timer_stat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  count_compare_timer u_count_compare_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .cmp_wr(cmp_wr), .wr_data(wr_data), .count_hold(count_hold),
    .arch_rev(arch_rev), .count_q(count_q), .timer_irq(timer_irq),
    .timer_stat(timer_stat)
  );

  // behavioural reference
  logic [31:0] m_count = '0;
  logic [31:0] m_cmp   = '0;
  bit          m_irq   = 0;
  bit          m_stat  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0; m_cmp = 0; m_irq = 0; m_stat = 0;
    end else begin
      bit stepping, matched;
      stepping = tick_en && !count_hold && !cnt_wr;
      matched  = stepping && (m_count + 32'd1 == m_cmp);
      if (cmp_wr) begin
        m_irq = 0; m_stat = 0;
      end else if (matched) begin
        m_irq = 1;
        if (arch_rev == 3'd1) m_stat = 1;
      end
      if (cmp_wr) m_cmp = wr_data;
      if (cnt_wr) m_count = wr_data;
      else if (stepping) m_count = m_count + 32'd1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(count_q == m_count, "R2", "count", count_q, m_count);
      chk(timer_irq == m_irq, "R5", "irq", timer_irq, m_irq);
      chk(timer_stat == (m_stat && arch_rev == 3'd1), "R9", "stat",
          timer_stat, m_stat && arch_rev == 3'd1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cnt(input logic [31:0] v);
    cnt_wr = 1; wr_data = v; step(1); cnt_wr = 0;
  endtask

  task automatic write_cmp(input logic [31:0] v);
    cmp_wr = 1; wr_data = v; step(1); cmp_wr = 0;
  endtask

  task automatic run_to(input logic [31:0] v);
    for (int i = 0; i < 1000 && count_q != v; i++) step(1);
  endtask

  initial begin
    step(3);
    chk(count_q == 0 && timer_irq == 0 && timer_stat == 0, "R1", "reset outputs",
        {count_q, timer_irq, timer_stat}, 0);
    rst_n = 1;
    step(1);
    chk(count_q == 0 && timer_irq == 0, "R1", "after release", count_q, 0);

    // R2 basic counting
    tick_en = 1; step(10);
    chk(count_q == 10, "R2", "count after 10 ticks", count_q, 10);
    tick_en = 0; step(4);
    chk(count_q == 10, "R2", "no tick no change", count_q, 10);

    // R3 freeze
    tick_en = 1; count_hold = 1; step(6);
    chk(count_q == 10, "R3", "held count", count_q, 10);
    // R4 write while held
    write_cnt(32'd100);
    chk(count_q == 100, "R4", "load while held", count_q, 100);
    count_hold = 0;

    // R5 R8 match on revision 1
    tick_en = 0;
    write_cnt(32'd0);
    write_cmp(32'd20);
    tick_en = 1;
    run_to(32'd19);
    chk(timer_irq == 0, "R5", "irq before match", timer_irq, 0);
    step(1);
    chk(count_q == 20 && timer_irq == 1, "R5", "irq at match", timer_irq, 1);
    chk(timer_stat == 1, "R8", "stat at match rev1", timer_stat, 1);

    // R6 sticky past match
    step(15);
    chk(timer_irq == 1, "R6", "irq held past match", timer_irq, 1);
    // R4 count write keeps pending irq
    write_cnt(32'd500);
    chk(timer_irq == 1 && count_q == 500, "R4", "count write keeps irq", timer_irq, 1);

    // R7 R9 compare write clears
    write_cmp(32'd3000);
    chk(timer_irq == 0, "R7", "irq cleared", timer_irq, 0);
    chk(timer_stat == 0, "R9", "stat cleared", timer_stat, 0);

    // R4 write onto compare value does not raise
    tick_en = 0;
    write_cnt(32'd3000);
    step(2);
    chk(timer_irq == 0, "R4", "load equal to compare", timer_irq, 0);

    // R8 R9 other revision
    arch_rev = 3'd2;
    write_cmp(32'd3005);
    tick_en = 1;
    run_to(32'd3005);
    chk(timer_irq == 1, "R5", "irq rev2", timer_irq, 1);
    chk(timer_stat == 0, "R9", "stat masked rev2", timer_stat, 0);
    arch_rev = 3'd1;
    step(1);
    chk(timer_stat == 0, "R8", "no stat from rev2 match", timer_stat, 0);

    // R2 wrap with compare after wrap
    tick_en = 0;
    write_cmp(32'd1);
    write_cnt(32'hFFFF_FFFE);
    tick_en = 1; step(1);
    chk(count_q == 32'hFFFF_FFFF, "R2", "top value", count_q, 32'hFFFF_FFFF);
    step(1);
    chk(count_q == 0, "R2", "wrap to zero", count_q, 0);
    step(1);
    chk(timer_irq == 1 && timer_stat == 1, "R5", "match after wrap", timer_irq, 1);

    // R7 compare write on same edge as match
    tick_en = 0;
    write_cmp(32'd50);
    write_cnt(32'd48);
    tick_en = 1; step(1);
    cmp_wr = 1; wr_data = 32'd50; step(1); cmp_wr = 0;
    chk(count_q == 50 && timer_irq == 0, "R7", "clear wins over match", timer_irq, 0);

    // random mix, reference compared each clock
    for (int i = 0; i < 4000; i++) begin
      tick_en    = ($urandom % 4) != 0;
      count_hold = ($urandom % 8) == 0;
      cnt_wr     = ($urandom % 40) == 0;
      cmp_wr     = !cnt_wr && (($urandom % 30) == 0);
      wr_data    = count_q + ($urandom % 12);
      arch_rev   = (($urandom % 4) != 0) ? 3'd1 : 3'($urandom);
      step(1);
    end
    cnt_wr = 0; cmp_wr = 0;
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule